// File: doc/BRIEF.md
# Shared-Count Pin Debouncer

This block filters eight synchronized input pins before they reach the input register and the interrupt edge detector. A single stable-time register, counted in millisecond ticks, sets the wait for every pin. Each pin has its own enable bit. A pin with its enable set only passes a new level once that level has held for the programmed number of ticks. A pin with its enable clear passes straight through.

Software programs the block through a simple write bus. Writing the count register sets the shared stable time. The enables are changed through a masked-write register, so one pin can be switched on or off without a read-modify-write. A strobe from outside the block supplies the millisecond tick.

Top module: `pin_debouncer`

## Requirements
- R1: A pin whose enable bit is 0 drives `pinOut` equal to its `pinIn` in the same cycle.
- R2: While the shared count register holds 0, every pin drives `pinOut` equal to `pinIn`, whatever its enable bit.
- R3: For an enabled pin with count N (1 to 255), `pinOut` takes the new input level at the clock edge of the N-th `msTick` cycle during which the input has differed from the accepted level. Before that edge `pinOut` keeps the old accepted level.
- R4: If an enabled pin's input returns to its accepted level in any cycle, its tick counter restarts from zero and `pinOut` does not change.
- R5: A write to address 0xF0 loads `regWrData[7:0]` into the count register, which all pins share, from the next cycle on.
- R6: A write to address 0xB0 updates enable bit i to `regWrData[i]` only when `regWrData[8+i]` is 1. An enable whose bit 8+i is 0 keeps its value.
- R7: Reset clears all enables and the count, and loads each accepted level from the current input, so `pinOut` equals `pinIn` after reset.
- R8: Writes to any address other than 0xF0 and 0xB0 leave the count and the enables unchanged.
- R9: If the count is lowered while a pin is waiting, the pin accepts on its next qualifying tick once its counter plus one reaches the new count.
- R10: Each pin keeps its own counter, so activity on one pin does not change the timing of another pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| pinIn | input | 8 | Synchronized raw pin levels |
| msTick | input | 1 | One-cycle strobe, once per millisecond |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register write address |
| regWrData | input | 16 | Register write data |
| pinOut | output | 8 | Filtered pin levels |

## Verification
The bench builds the block with its default parameters: eight pins, an 8-bit count, and the count and masked-enable registers at 0xF0 and 0xB0. Because the 8-bit count is small, the full 255-tick wait is reachable with a tick on every cycle. Short counts of 1 to 5, written while the bench runs, make accepts, restarts and mid-wait count changes happen often during the random phase. Random masked writes, random tick spacing and random pin bounce together cover mixes of enabled and bypassed pins.

// File: rtl/pin_debouncer_pkg.sv
package pin_debouncer_pkg;
  // Strobes from the register decoder to the filter datapath
  typedef struct packed {
    logic tick;      // millisecond strobe
    logic limitWr;   // load the shared count
    logic enMaskWr;  // masked update of the per-pin enables
  } dbStrobe_t;
endpackage

// File: rtl/pin_debouncer_ctrl.sv
module pin_debouncer_ctrl
  import pin_debouncer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CNT_ADDR  = 8'hF0,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'hB0
) (
  input  logic              msTick,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output dbStrobe_t         strobe
);
  always_comb begin
    strobe.tick     = msTick;
    strobe.limitWr  = regWrEn && (regAddr == CNT_ADDR);
    strobe.enMaskWr = regWrEn && (regAddr == MASK_ADDR);
  end
endmodule

// File: rtl/pin_debouncer_cell.sv
module pin_debouncer_cell #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rawIn,
  input  logic             enable,
  input  logic [CNT_W-1:0] limit,
  input  logic             tick,
  output logic             heldVal,
  output logic             pinOut
);
  logic [CNT_W-1:0] tickCnt;
  logic             active;
  logic             reached;

  assign active  = enable && (limit != '0);
  assign reached = ({1'b0, tickCnt} + 1'b1) >= {1'b0, limit};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldVal <= rawIn;
      tickCnt <= '0;
    end else if (!active) begin
      heldVal <= rawIn;
      tickCnt <= '0;
    end else if (rawIn == heldVal) begin
      tickCnt <= '0;
    end else if (tick) begin
      if (reached) begin
        heldVal <= rawIn;
        tickCnt <= '0;
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  assign pinOut = active ? heldVal : rawIn;
endmodule

// File: rtl/pin_debouncer_dp.sv
module pin_debouncer_dp
  import pin_debouncer_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dbStrobe_t         strobe,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   enable,
  output logic [CNT_W-1:0]  limit,
  output logic [PINS-1:0]   heldVal,
  output logic [PINS-1:0]   pinOut
);
  localparam int WEN_LSB = PINS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      limit <= '0;
    end else if (strobe.limitWr) begin
      limit <= regWrData[CNT_W-1:0];
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rstN) begin
        enable[i] <= 1'b0;
      end else if (strobe.enMaskWr && regWrData[WEN_LSB+i]) begin
        enable[i] <= regWrData[i];
      end
    end

    pin_debouncer_cell #(.CNT_W(CNT_W)) u_cell (
      .clk    (clk),
      .rstN   (rstN),
      .rawIn  (pinIn[i]),
      .enable (enable[i]),
      .limit  (limit),
      .tick   (strobe.tick),
      .heldVal(heldVal[i]),
      .pinOut (pinOut[i])
    );
  end
endmodule

// File: rtl/pin_debouncer.sv
module pin_debouncer
  import pin_debouncer_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] UPPER_OFFSET = 8'h80,
  parameter logic [ADDR_W-1:0] CNT_ADDR     = 8'hF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PINS-1:0]   pinIn,
  input  logic              msTick,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [PINS-1:0]   pinOut
);
  localparam logic [ADDR_W-1:0] MASK_ADDR = UPPER_OFFSET + ADDR_W'(8'h30);

  dbStrobe_t         strobe;
  logic [PINS-1:0]   enable;
  logic [CNT_W-1:0]  limit;
  logic [PINS-1:0]   heldVal;

  pin_debouncer_ctrl #(
    .ADDR_W(ADDR_W), .CNT_ADDR(CNT_ADDR), .MASK_ADDR(MASK_ADDR)
  ) u_ctrl (
    .msTick (msTick),
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .strobe (strobe)
  );

  pin_debouncer_dp #(
    .PINS(PINS), .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .regWrData(regWrData),
    .pinIn    (pinIn),
    .enable   (enable),
    .limit    (limit),
    .heldVal  (heldVal),
    .pinOut   (pinOut)
  );
endmodule

// File: rtl/pin_debouncer_chk.sv
module pin_debouncer_chk #(
  parameter int PINS   = 8,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] CNT_ADDR  = 8'hF0,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'hB0
) (
  input logic              clk,
  input logic              rstN,
  input logic [PINS-1:0]   pinIn,
  input logic              msTick,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [PINS-1:0]   pinOut,
  input logic [PINS-1:0]   enable,
  input logic [CNT_W-1:0]  limit,
  input logic [PINS-1:0]   heldVal
);
  assert_zero_count_bypass_R2: assert property (@(posedge clk) disable iff (!rstN)
    (limit == '0) |-> (pinOut == pinIn));

  assert_count_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == CNT_ADDR) |=> (limit == $past(regWrData[CNT_W-1:0])));

  for (genvar i = 0; i < PINS; i++) begin : g_chk
    assert_disabled_bypass_R1: assert property (@(posedge clk) disable iff (!rstN)
      !enable[i] |-> (pinOut[i] == pinIn[i]));

    // R3/R4: an active pin changes its accepted level only on a tick with a differing input
    assert_hold_without_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
      (enable[i] && limit != '0 && (!msTick || pinIn[i] == heldVal[i]))
        |=> $stable(heldVal[i]));

    assert_masked_set_R6: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && regAddr == MASK_ADDR && regWrData[PINS+i])
        |=> (enable[i] == $past(regWrData[i])));

    assert_masked_keep_R6: assert property (@(posedge clk) disable iff (!rstN)
      !(regWrEn && regAddr == MASK_ADDR && regWrData[PINS+i]) |=> $stable(enable[i]));
  end
endmodule

bind pin_debouncer pin_debouncer_chk #(
  .PINS(PINS), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .CNT_ADDR(CNT_ADDR), .MASK_ADDR(MASK_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .pinIn(pinIn), .msTick(msTick), .regWrEn(regWrEn),
  .regAddr(regAddr), .regWrData(regWrData), .pinOut(pinOut),
  .enable(enable), .limit(limit), .heldVal(heldVal)
);

// File: tb/pin_debouncer_bench.sv
module pin_debouncer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  pinIn = 8'h00;
  logic        msTick = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [15:0] regWrData = 16'h0000;
  logic [7:0]  pinOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model of the requirements
  logic [7:0] mAcc = 8'h00;
  logic [7:0] mEn  = 8'h00;
  logic [7:0] mLim = 8'h00;
  int         mCnt [8];

  always #10 clk = ~clk;

  pin_debouncer u_pin_debouncer (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .msTick(msTick),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .pinOut(pinOut)
  );

  function automatic logic [7:0] expOut();
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = (mEn[i] && mLim != 0) ? mAcc[i] : pinIn[i];
    return r;
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pinOut=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Called just after a falling edge with the inputs already set
  task automatic step(input string tag);
    logic [7:0] nAcc, nEn, nLim;
    int nCnt [8];
    #2 check(pinOut, expOut(), tag);
    nAcc = mAcc; nEn = mEn; nLim = mLim;
    for (int i = 0; i < 8; i++) begin
      nCnt[i] = mCnt[i];
      if (!(mEn[i] && mLim != 0)) begin
        nAcc[i] = pinIn[i]; nCnt[i] = 0;
      end else if (pinIn[i] == mAcc[i]) begin
        nCnt[i] = 0;
      end else if (msTick) begin
        if (mCnt[i] + 1 >= int'(mLim)) begin
          nAcc[i] = pinIn[i]; nCnt[i] = 0;
        end else nCnt[i] = mCnt[i] + 1;
      end
    end
    if (regWrEn && regAddr == 8'hF0) nLim = regWrData[7:0];
    if (regWrEn && regAddr == 8'hB0)
      for (int i = 0; i < 8; i++) if (regWrData[8+i]) nEn[i] = regWrData[i];
    @(posedge clk);
    mAcc = nAcc; mEn = nEn; mLim = nLim;
    for (int i = 0; i < 8; i++) mCnt[i] = nCnt[i];
    @(negedge clk);
    msTick = 1'b0; regWrEn = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input string tag);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step(tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      msTick = 1'b1;
      step(tag);
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 8; i++) mCnt[i] = 0;
    pinIn = 8'hA5;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    mAcc = 8'hA5;
    // R7: after reset the output equals the input
    step("R7");
    check(pinOut, 8'hA5, "R7 reset level");

    // R1: enables clear, output follows input immediately
    pinIn = 8'h3C;
    #2 check(pinOut, 8'h3C, "R1 bypass");
    step("R1");

    // R5 / R6: count 3, enable pins 0..3 only (bits 15:8 write enables, 7:0 values)
    wr(8'hF0, 16'h0003, "R5");
    wr(8'hB0, 16'h0F0F, "R6");
    pinIn = 8'hC3; // pins 0,1 rise, 2,3 fall, upper nibble flips and bypasses
    step("R6");
    check(pinOut, 8'hCC, "R6 upper bypass, lower held");
    ticks(2, "R3");
    check(pinOut, 8'hCC, "R3 held before third tick");
    ticks(1, "R3");
    check(pinOut, 8'hC3, "R3 accepted after third tick");

    // R4: bounce back restarts
    pinIn = 8'hC2; ticks(2, "R4");
    pinIn = 8'hC3; step("R4");
    pinIn = 8'hC2; ticks(2, "R4");
    check(pinOut, 8'hC3, "R4 restart after bounce");
    ticks(1, "R4");
    check(pinOut, 8'hC2, "R4 accept after full wait");

    // R6: masked write that clears only pin 0
    wr(8'hB0, 16'h0100, "R6");
    pinIn = 8'hC3; step("R6");
    check(pinOut, 8'hC3, "R6 pin0 now bypass");
    pinIn = 8'hC1; step("R6");
    check(pinOut, 8'hC3, "R6 pin1 still held");

    // R9: lower the count mid-wait
    wr(8'hF0, 16'h0005, "R9");
    ticks(2, "R9");
    wr(8'hF0, 16'h0002, "R9");
    check(pinOut, 8'hC3, "R9 still held");
    ticks(1, "R9");
    check(pinOut, 8'hC1, "R9 accept after lowered count");

    // R8: writes to other addresses ignored
    wr(8'h40, 16'hFFFF, "R8");
    wr(8'hF1, 16'h0000, "R8");
    pinIn = 8'hC3; ticks(1, "R8");
    check(pinOut, 8'hC1, "R8 count and enables unchanged");
    ticks(1, "R8");
    check(pinOut, 8'hC3, "R8 accept");

    // R2: count 0 bypasses even enabled pins
    wr(8'hB0, 16'hFFFF, "R2");
    wr(8'hF0, 16'h0000, "R2");
    pinIn = 8'h5A;
    #2 check(pinOut, 8'h5A, "R2 zero count bypass");
    step("R2");

    // R3 boundary: count 255 with a tick every cycle
    wr(8'hF0, 16'h00FF, "R3");
    pinIn = 8'hA5;
    ticks(254, "R3");
    check(pinOut, 8'h5A, "R3 held at 254 ticks");
    ticks(1, "R3");
    check(pinOut, 8'hA5, "R3 accept at 255 ticks");

    // R10: random mix, every step compared with the model
    wr(8'hF0, 16'h0002, "R10");
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < 8; i++)
        if ($urandom % 10 == 0) pinIn[i] = ~pinIn[i];
      msTick = ($urandom % 3 == 0);
      if ($urandom % 40 == 0) begin
        regWrEn = 1'b1;
        case ($urandom % 3)
          0: begin regAddr = 8'hF0; regWrData = 16'($urandom % 6); end
          1: begin regAddr = 8'hB0; regWrData = 16'($urandom); end
          default: begin regAddr = 8'($urandom); regWrData = 16'($urandom); end
        endcase
      end
      step("R10");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule